// File: doc/BRIEF.md
# Scaled Product and Saturating Accumulator Path

This block is the 32-bit arithmetic datapath that sits between a multiplier's product register and the accumulator of a fixed-point processor. In each enabled cycle it adds one operand to, or subtracts one operand from, the accumulator it holds. The operand is either the 32-bit product, scaled by a two-bit product-shift mode, or a 16-bit data word. The data word is widened by zero or sign extension, and it can optionally be moved up by 16 bits.

Each update also produces a carry bit, held inside the block, and a one-cycle overflow pulse for the status logic. With overflow mode set, an overflowing result is clamped to the most positive or the most negative 32-bit value. With overflow mode clear, the result wraps. The multiplier, instruction decode and the status register itself are outside this block. The mode bits arrive as plain inputs.

Top module: `acc_scale_path`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `acc_q` = 0, `carry_q` = 1 and `ovf_pulse` = 0.
- R2: At a rising edge with `en` low, `acc_q` and `carry_q` keep their values and `ovf_pulse` is 0, whatever the other inputs are.
- R3: `op_sel` picks the operation: 00 gives acc + scaled product, 01 gives acc − scaled product, 10 gives acc + data operand, and 11 gives acc − data operand.
- R4: `pshift` scales the product before it enters the adder. 00 passes it unchanged, 01 shifts it left by 1 with zero fill, 10 shifts it left by 4 with zero fill, and 11 shifts it right by 6 with sign fill. `prod_in` is only read.
- R5: The data operand is sign-extended to 32 bits when `sxm` = 1 and `force_uns` = 0. Otherwise it is zero-extended.
- R6: When `shift16` = 1 on a data operation, the operand is `data_in` in bits 31:16 with zeros in bits 15:0. `shift16` has no effect on product operations.
- R7: If an enabled operation is not a data operation with `shift16` set, the new carry is the unsigned carry-out for an addition, or the inverse of the unsigned borrow for a subtraction.
- R8: For a data operation with `shift16` = 1, an addition can only set carry (old carry OR carry-out). A subtraction can only clear it (old carry AND NOT borrow).
- R9: With `ovm` = 0, the accumulator takes the 32-bit wrapped result, even on signed overflow.
- R10: With `ovm` = 1, a signed overflow loads 0x7FFFFFFF if the exact result is positive, or 0x80000000 if it is negative.
- R11: `ovf_pulse` is 1 for exactly the cycle after an enabled operation whose exact signed result lies outside the 32-bit range, whatever `ovm` is. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Update strobe for accumulator, carry and overflow pulse |
| op_sel | input | 2 | Operation select (see R3) |
| pshift | input | 2 | Product scaling mode (see R4) |
| ovm | input | 1 | 1 = saturate on overflow, 0 = wrap |
| sxm | input | 1 | 1 = sign-extend the data operand |
| force_uns | input | 1 | 1 = zero-extend the data operand regardless of `sxm` |
| shift16 | input | 1 | Place the data operand in the upper half, with sticky carry rules |
| prod_in | input | 32 | Product register value |
| data_in | input | 16 | Data word |
| acc_q | output | 32 | Accumulator |
| carry_q | output | 1 | Carry bit |
| ovf_pulse | output | 1 | One-cycle signed overflow indication |

## Verification
Every state element here is visible at a port one cycle after it is written, so a wrong scaling shift, extension or adder result shows on `acc_q` at the first sampling point after the enabled edge. A wrong carry rule shows on `carry_q` in the same cycle. An error in the sticky rules stays hidden unless the old carry happens to hold the value that the rule forbids changing, so the sweep reaches both old-carry states under each qualifier setting. Saturation faults show only when a signed overflow occurs with `ovm` set. The bench therefore runs operands from a running pseudo-random accumulator, which overflows often, across all 64 mode combinations.

// File: rtl/acc_path_pkg.sv
package acc_path_pkg;

  typedef enum logic [1:0] {
    OP_ADD_PROD = 2'b00,
    OP_SUB_PROD = 2'b01,
    OP_ADD_DATA = 2'b10,
    OP_SUB_DATA = 2'b11
  } acc_op_e;

  typedef enum logic [1:0] {
    PS_PASS   = 2'b00,
    PS_LEFT_A = 2'b01,
    PS_LEFT_B = 2'b10,
    PS_RIGHT  = 2'b11
  } pscale_e;

  typedef struct packed {
    logic carry;
    logic ovf;
    logic sat;
  } alu_flags_t;

endpackage

// File: rtl/prod_scaler.sv
module prod_scaler
  import acc_path_pkg::*;
#(
  parameter int W      = 32,
  parameter int LSH_A  = 1,
  parameter int LSH_B  = 4,
  parameter int RSH    = 6
) (
  input  logic [W-1:0] prod,
  input  logic [1:0]   mode,
  output logic [W-1:0] scaled
);

  function automatic logic [W-1:0] scale_fn(input logic [W-1:0] p, input pscale_e m);
    logic [W-1:0] r;
    case (m)
      PS_PASS:   r = p;
      PS_LEFT_A: r = p << LSH_A;
      PS_LEFT_B: r = p << LSH_B;
      default:   r = W'($signed(p) >>> RSH);
    endcase
    return r;
  endfunction

  assign scaled = scale_fn(prod, pscale_e'(mode));

endmodule

// File: rtl/data_aligner.sv
module data_aligner #(
  parameter int W     = 32,
  parameter int DW    = 16,
  parameter int SHIFT = 16
) (
  input  logic [DW-1:0] data,
  input  logic          sxm,
  input  logic          force_uns,
  input  logic          shift_en,
  output logic [W-1:0]  aligned
);

  localparam int PAD = W - DW;

  function automatic logic [W-1:0] extend_fn(input logic [DW-1:0] d, input logic signed_ext);
    logic fill;
    fill = signed_ext & d[DW-1];
    return {{PAD{fill}}, d};
  endfunction

  logic [W-1:0] extended;

  assign extended = extend_fn(data, sxm & ~force_uns);
  assign aligned  = shift_en ? (extended << SHIFT) : extended;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_path_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] operand,
  input  logic         subtract,
  input  logic         sticky,
  input  logic         carry_old,
  input  logic         ovm,
  output logic [W-1:0] result,
  output alu_flags_t   flags
);

  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W:0] addsub_fn(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic sub);
    return sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
  endfunction

  function automatic logic ovf_fn(input logic a_s, input logic b_s, input logic r_s,
                                  input logic sub);
    return sub ? ((a_s != b_s) && (r_s != a_s)) : ((a_s == b_s) && (r_s != a_s));
  endfunction

  function automatic logic carry_fn(input logic cout, input logic sub, input logic stick,
                                    input logic old);
    logic plain;
    plain = sub ? ~cout : cout;
    if (!stick) return plain;
    return sub ? (old & plain) : (old | plain);
  endfunction

  logic [W:0]   wide;
  logic [W-1:0] raw;
  logic         ovf;

  assign wide = addsub_fn(acc, operand, subtract);
  assign raw  = wide[W-1:0];
  assign ovf  = ovf_fn(acc[W-1], operand[W-1], raw[W-1], subtract);

  assign flags.carry = carry_fn(wide[W], subtract, sticky, carry_old);
  assign flags.ovf   = ovf;
  assign flags.sat   = ovf & ovm;
  assign result      = flags.sat ? (acc[W-1] ? MAX_NEG : MAX_POS) : raw;

endmodule

// File: rtl/acc_scale_path.sv
module acc_scale_path
  import acc_path_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        op_sel,
  input  logic [1:0]        pshift,
  input  logic              ovm,
  input  logic              sxm,
  input  logic              force_uns,
  input  logic              shift16,
  input  logic [ACC_W-1:0]  prod_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [ACC_W-1:0]  acc_q,
  output logic              carry_q,
  output logic              ovf_pulse
);

  acc_op_e          op;
  logic             is_data;
  logic             is_sub;
  logic             hi_shift;
  logic [ACC_W-1:0] prod_scaled;
  logic [ACC_W-1:0] data_op;
  logic [ACC_W-1:0] operand;
  logic [ACC_W-1:0] acc_next;
  alu_flags_t       flags;

  // Named event wires for the checker
  logic             ovf_event;
  logic             sat_event;

  assign op       = acc_op_e'(op_sel);
  assign is_data  = (op == OP_ADD_DATA) || (op == OP_SUB_DATA);
  assign is_sub   = (op == OP_SUB_PROD) || (op == OP_SUB_DATA);
  assign hi_shift = is_data & shift16;

  prod_scaler #(.W(ACC_W)) u_scaler (
    .prod   (prod_in),
    .mode   (pshift),
    .scaled (prod_scaled)
  );

  data_aligner #(.W(ACC_W), .DW(DATA_W), .SHIFT(DATA_W)) u_align (
    .data      (data_in),
    .sxm       (sxm),
    .force_uns (force_uns),
    .shift_en  (hi_shift),
    .aligned   (data_op)
  );

  assign operand = is_data ? data_op : prod_scaled;

  acc_alu #(.W(ACC_W)) u_alu (
    .acc       (acc_q),
    .operand   (operand),
    .subtract  (is_sub),
    .sticky    (hi_shift),
    .carry_old (carry_q),
    .ovm       (ovm),
    .result    (acc_next),
    .flags     (flags)
  );

  assign ovf_event = flags.ovf;
  assign sat_event = flags.sat;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      carry_q   <= 1'b1;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= en & flags.ovf;
      if (en) begin
        acc_q   <= acc_next;
        carry_q <= flags.carry;
      end
    end
  end

endmodule

// File: rtl/acc_scale_path_chk.sv
module acc_scale_path_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [1:0]   op_sel,
  input logic         shift16,
  input logic [W-1:0] acc_q,
  input logic         carry_q,
  input logic         ovf_pulse,
  input logic         ovf_event,
  input logic         sat_event
);

  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && carry_q && !ovf_pulse);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_q) && $stable(carry_q) && !ovf_pulse);

  assert_add_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (en && op_sel == 2'b10 && shift16 && carry_q) |=> carry_q);

  assert_sub_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (en && op_sel == 2'b11 && shift16 && !carry_q) |=> !carry_q);

  assert_saturate_R10: assert property (@(posedge clk) disable iff (rst)
    (en && sat_event) |=> (acc_q == MAX_POS) || (acc_q == MAX_NEG));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (en && ovf_event) |=> ovf_pulse);

  assert_no_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (en && !ovf_event) |=> !ovf_pulse);

endmodule

bind acc_scale_path acc_scale_path_chk #(.W(ACC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .op_sel    (op_sel),
  .shift16   (shift16),
  .acc_q     (acc_q),
  .carry_q   (carry_q),
  .ovf_pulse (ovf_pulse),
  .ovf_event (ovf_event),
  .sat_event (sat_event)
);

// File: tb/acc_scale_path_tb.sv
module acc_scale_path_tb;

  localparam int CLK_PERIOD = 10;
  localparam longint MASK32 = 64'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [1:0]  op_sel = '0;
  logic [1:0]  pshift = '0;
  logic        ovm = 1'b0;
  logic        sxm = 1'b0;
  logic        force_uns = 1'b0;
  logic        shift16 = 1'b0;
  logic [31:0] prod_in = '0;
  logic [15:0] data_in = '0;
  logic [31:0] acc_q;
  logic        carry_q;
  logic        ovf_pulse;

  int checks = 0;
  int fails = 0;

  logic [31:0] m_acc;
  logic        m_carry;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_scale_path u_dut (
    .clk(clk), .rst(rst), .en(en), .op_sel(op_sel), .pshift(pshift), .ovm(ovm),
    .sxm(sxm), .force_uns(force_uns), .shift16(shift16), .prod_in(prod_in),
    .data_in(data_in), .acc_q(acc_q), .carry_q(carry_q), .ovf_pulse(ovf_pulse)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Operand as the requirements define it (R3 to R6)
  function automatic longint ref_operand(input logic [1:0] op, input logic [1:0] ps,
      input logic sx, input logic fu, input logic sh, input logic [31:0] p,
      input logic [15:0] d);
    longint v;
    if (!op[1]) begin
      case (ps)
        2'b00: v = longint'(p);
        2'b01: v = (longint'(p) * 2) & MASK32;
        2'b10: v = (longint'(p) * 16) & MASK32;
        default: v = (longint'($signed(p)) >>> 6) & MASK32;
      endcase
    end else if (sh) begin
      v = (longint'(d) * 65536) & MASK32;
    end else if (sx && !fu && d[15]) begin
      v = longint'(d) + 64'hFFFF_0000;
    end else begin
      v = longint'(d);
    end
    return v;
  endfunction

  task automatic do_op(input logic [1:0] op, input logic [1:0] ps, input logic sx,
                       input logic fu, input logic sh, input logic ov,
                       input logic [31:0] p, input logic [15:0] d);
    longint uo, ua, sa, so, tv, res;
    logic exp_ovf, exp_c, plain;
    string lbl_acc, lbl_c;
    uo = ref_operand(op, ps, sx, fu, sh, p, d);
    ua = longint'(m_acc);
    sa = longint'($signed(m_acc));
    so = (uo >= 64'h8000_0000) ? uo - 64'h1_0000_0000 : uo;
    tv = op[0] ? sa - so : sa + so;
    exp_ovf = (tv > 64'sd2147483647) || (tv < -64'sd2147483648);
    if (exp_ovf && ov) res = (tv > 0) ? 64'h7FFF_FFFF : 64'h8000_0000;
    else res = tv & MASK32;
    plain = op[0] ? (ua >= uo) : ((ua + uo) > MASK32);
    if (op[1] && sh) exp_c = op[0] ? (m_carry & plain) : (m_carry | plain);
    else exp_c = plain;
    lbl_acc = {op[1] ? (sh ? "R3 R6" : "R3 R5") : "R3 R4", ov ? " R10" : " R9"};
    lbl_c = (op[1] && sh) ? "R8 carry" : "R7 carry";
    @(negedge clk);
    op_sel = op; pshift = ps; sxm = sx; force_uns = fu; shift16 = sh; ovm = ov;
    prod_in = p; data_in = d; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    check(lbl_acc, longint'(acc_q), res);
    check(lbl_c, longint'(carry_q), longint'(exp_c));
    check("R11 overflow pulse", longint'(ovf_pulse), longint'(exp_ovf));
    m_acc = res[31:0];
    m_carry = exp_c;
  endtask

  task automatic idle_check();
    rng = next_rand(rng);
    op_sel = rng[1:0]; pshift = rng[3:2]; ovm = rng[4]; shift16 = rng[5];
    prod_in = rng; data_in = rng[31:16];
    @(negedge clk);
    check("R2 hold acc", longint'(acc_q), longint'(m_acc));
    check("R2 hold carry", longint'(carry_q), longint'(m_carry));
    check("R2 no pulse", longint'(ovf_pulse), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b1;
    @(negedge clk);
    rst = 1'b0; en = 1'b0;
    check("R1 acc", longint'(acc_q), 0);
    check("R1 carry", longint'(carry_q), 1);
    check("R1 pulse", longint'(ovf_pulse), 0);
    m_acc = '0;
    m_carry = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // Directed saturation corners, R10 and R9
    do_op(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 32'h7FFF_FFFF, 16'h0);
    do_op(2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0, 16'h0001);
    do_op(2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 16'h0001);
    do_op(2'b11, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0, 16'h0001);
    idle_check();
    // Sweep of every mode combination with a running accumulator
    for (int mode = 0; mode < 64; mode++) begin
      logic [5:0] m;
      m = 6'(mode);
      do_reset();
      rng = next_rand(rng);
      do_op(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, rng, 16'h0);
      for (int op = 0; op < 4; op++) begin
        for (int v = 0; v < 8; v++) begin
          logic [31:0] pv;
          rng = next_rand(rng);
          pv = rng;
          rng = next_rand(rng);
          do_op(2'(op), m[1:0], m[2], m[3], m[4], m[5], pv, rng[15:0]);
          if (v == 3) idle_check();
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule